// File: doc/BRIEF.md
# Frame Response Length and Spacing Supervisor

This block watches the response section of a byte-oriented serial frame, whether this node sends it or receives it. It takes the expected number of data bytes from one of two length sources. A short length code is used for normal frames and a wider extended length is used for long frames. It counts the data bytes that follow the frame-information byte and lets a fixed number of check bytes pass. It then times the end-of-frame period in bit times. A byte decoder upstream supplies start-of-byte and byte-complete strobes with a byte-kind tag, a bit-time strobe and the sampled bus level.

A length error is found from what happens on the bus, not from comparing fields. If the bus goes dominant inside the end-of-frame period, too many bytes were sent. If the bus stays recessive for more than nine bit times before the expected count is reached, too few bytes were sent. Either error still ends the response with a response-done pulse, so the frame is not aborted. A clean end of the end-of-frame period raises a completion pulse together with response-done.

A separate sticky timeout flag reports any inter-byte gap inside a frame that is longer than a programmable limit. An abort input from other error sources returns the block to idle at once.

Top module: `frame_len_checker`

## Requirements
- R1: The expected data-byte count is `ext_len` when `long_frame` is 1 and the zero-extended `len_code` when it is 0, captured when the frame-information byte completes; a count of 0 moves straight to the check bytes.
- R2: Byte kinds are encoded on `byte_kind` as 0 = header, 1 = frame information, 2 = body (data or check byte), 3 = ignored. Body bytes that complete before the frame-information byte are not counted.
- R3: After the expected body bytes and then CRC_BYTES (default 1) further body bytes, the block times EOF_BITS (default 11) bit ticks with the bus recessive. On the last of these ticks it pulses `frame_ok` and `resp_done` together for one cycle and returns to idle.
- R4: A bit tick with the bus dominant, or a byte start, during the end-of-frame period pulses `len_err`, `err_too_many` and `resp_done`, with no `frame_ok`.
- R5: While fewer data bytes than expected have arrived, a recessive gap of more than 9 bit ticks since the last byte start pulses `len_err`, `err_too_few` and `resp_done`, with no `frame_ok`.
- R6: The gap count restarts on every byte start, so a gap of exactly 9 bit ticks between bytes raises no error.
- R7: With `to_enable` high, a gap inside a frame (from header to last check byte) longer than `to_limit` bit ticks sets the `timeout` flag.
- R8: While `to_enable` stays high after a timeout, `to_clear` does not clear `timeout`. Once `to_enable` is low, `to_clear` clears it, and it stays clear when `to_enable` is raised again.
- R9: `abort` returns the block to idle (`busy` low) on the next cycle with no `resp_done`, and later bit ticks produce no pulse.
- R10: After reset, `busy`, `resp_done`, `frame_ok`, `len_err`, `err_too_many`, `err_too_few` and `timeout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_start | input | 1 | Start bit of a byte seen on the bus |
| byte_done | input | 1 | Byte completed, kind on byte_kind |
| byte_kind | input | 2 | 0 header, 1 frame information, 2 body, 3 ignored |
| bit_tick | input | 1 | One strobe per bit time |
| bus_level | input | 1 | Sampled bus level, 1 = recessive |
| long_frame | input | 1 | Selects extended length source |
| len_code | input | 4 | Normal-frame data length |
| ext_len | input | 8 | Long-frame data length |
| to_enable | input | 1 | Timeout detection enable |
| to_limit | input | 8 | Timeout gap limit in bit times |
| to_clear | input | 1 | Clear request for the timeout flag |
| abort | input | 1 | Return to idle from other error sources |
| busy | output | 1 | A frame response is being supervised |
| resp_done | output | 1 | Response finished (clean or with length error) |
| frame_ok | output | 1 | Clean completion after end-of-frame |
| len_err | output | 1 | Length error pulse |
| err_too_many | output | 1 | Length error cause: excess bytes |
| err_too_few | output | 1 | Length error cause: missing bytes |
| timeout | output | 1 | Sticky inter-byte timeout flag |

## Verification
A wrong byte count or a wrong length source moves the start of the end-of-frame window. The next body byte then lands inside that window, and an excess-byte error appears at the ports instead of `frame_ok` one cycle after the byte start. A gap counter that is not restarted, or that uses the wrong limit, shows as a missing-byte error one tick early or late, or on a frame that has legal gaps. A timeout pending state that is kept or dropped wrongly shows at `timeout` within two cycles of the enable changing or of a clear.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef enum logic [1:0] {
        BK_HEAD = 2'd0,
        BK_INFO = 2'd1,
        BK_BODY = 2'd2,
        BK_NONE = 2'd3
    } byte_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INFO,
        ST_DATA,
        ST_CHECK,
        ST_EOF
    } flc_state_t;

    typedef struct packed {
        logic done;
        logic ok;
        logic many;
        logic few;
    } flc_event_t;

    localparam flc_event_t EV_NONE = '{done: 1'b0, ok: 1'b0, many: 1'b0, few: 1'b0};

    function automatic logic [7:0] pick_length(
        input logic       use_ext,
        input logic [3:0] code,
        input logic [7:0] ext
    );
        return use_ext ? ext : {4'd0, code};
    endfunction

endpackage

// File: rtl/flc_gap_counter.sv
module flc_gap_counter #(
    parameter int GAP_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic             recessive,
    output logic [GAP_W-1:0] gap
);
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            gap <= '0;
        end else if (tick && recessive && gap != GAP_MAX) begin
            gap <= gap + 1'b1;
        end
    end
endmodule

// File: rtl/flc_eof_timer.sv
module flc_eof_timer #(
    parameter int EOF_BITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic last
);
    localparam int EOF_W = $clog2(EOF_BITS + 1);
    localparam logic [EOF_W-1:0] LAST_IDX = EOF_W'(EOF_BITS - 1);

    logic [EOF_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && cnt != LAST_IDX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == LAST_IDX);
endmodule

// File: rtl/flc_timeout_flag.sv
module flc_timeout_flag #(
    parameter int TO_W  = 8,
    parameter int GAP_W = TO_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_frame,
    input  logic [GAP_W-1:0] gap,
    input  logic [TO_W-1:0]  limit,
    input  logic             enable,
    input  logic             clear,
    output logic             flag
);
    logic pending;
    logic over;

    assign over = in_frame && (gap > GAP_W'(limit));

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            flag    <= 1'b0;
        end else begin
            if (!enable) begin
                pending <= 1'b0;
            end else if (over) begin
                pending <= 1'b1;
            end
            flag <= (flag && !clear) || (enable && pending);
        end
    end
endmodule

// File: rtl/frame_len_checker.sv
module frame_len_checker
    import flc_pkg::*;
#(
    parameter int CODE_W    = 4,
    parameter int LEN_W     = 8,
    parameter int TO_W      = 8,
    parameter int EOF_BITS  = 11,
    parameter int GAP_LIMIT = 9,
    parameter int CRC_BYTES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_start,
    input  logic              byte_done,
    input  logic [1:0]        byte_kind,
    input  logic              bit_tick,
    input  logic              bus_level,
    input  logic              long_frame,
    input  logic [CODE_W-1:0] len_code,
    input  logic [LEN_W-1:0]  ext_len,
    input  logic              to_enable,
    input  logic [TO_W-1:0]   to_limit,
    input  logic              to_clear,
    input  logic              abort,
    output logic              busy,
    output logic              resp_done,
    output logic              frame_ok,
    output logic              len_err,
    output logic              err_too_many,
    output logic              err_too_few,
    output logic              timeout
);
    localparam int GAP_W = TO_W + 1;
    localparam int CRC_W = (CRC_BYTES > 1) ? $clog2(CRC_BYTES) : 1;
    localparam logic [CRC_W-1:0] CRC_LAST = CRC_W'(CRC_BYTES - 1);
    localparam logic [GAP_W-1:0] GAP_LIM  = GAP_W'(GAP_LIMIT);

    flc_state_t       state;
    flc_event_t       ev;
    logic [LEN_W-1:0] expect_len;
    logic [LEN_W-1:0] data_cnt;
    logic [CRC_W-1:0] crc_cnt;
    logic [GAP_W-1:0] gap;
    logic             eof_last;
    logic             got_done;
    byte_kind_t       kind;
    logic [LEN_W-1:0] sel_len;
    logic             in_frame;

    assign kind     = byte_kind_t'(byte_kind);
    assign got_done = byte_done && kind != BK_NONE;
    assign sel_len  = LEN_W'(pick_length(long_frame, 4'(len_code), 8'(ext_len)));
    assign in_frame = (state == ST_INFO) || (state == ST_DATA) || (state == ST_CHECK);

    flc_gap_counter #(.GAP_W(GAP_W)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .restart   (byte_start || state == ST_IDLE),
        .tick      (bit_tick),
        .recessive (bus_level),
        .gap       (gap)
    );

    flc_eof_timer #(.EOF_BITS(EOF_BITS)) u_eof (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_EOF),
        .tick (bit_tick && bus_level),
        .last (eof_last)
    );

    flc_timeout_flag #(.TO_W(TO_W), .GAP_W(GAP_W)) u_to (
        .clk      (clk),
        .rst      (rst),
        .in_frame (in_frame),
        .gap      (gap),
        .limit    (to_limit),
        .enable   (to_enable),
        .clear    (to_clear),
        .flag     (timeout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ev         <= EV_NONE;
            expect_len <= '0;
            data_cnt   <= '0;
            crc_cnt    <= '0;
        end else begin
            ev <= EV_NONE;
            if (abort) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (got_done && kind == BK_HEAD) begin
                            state <= ST_INFO;
                        end
                    end
                    ST_INFO: begin
                        if (got_done && kind == BK_INFO) begin
                            expect_len <= sel_len;
                            data_cnt   <= '0;
                            crc_cnt    <= '0;
                            state      <= (sel_len == '0) ? ST_CHECK : ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (gap > GAP_LIM) begin
                            ev    <= '{done: 1'b1, ok: 1'b0, many: 1'b0, few: 1'b1};
                            state <= ST_IDLE;
                        end else if (got_done && kind == BK_BODY) begin
                            data_cnt <= data_cnt + 1'b1;
                            if (data_cnt + 1'b1 == expect_len) begin
                                state <= ST_CHECK;
                            end
                        end
                    end
                    ST_CHECK: begin
                        if (got_done && kind == BK_BODY) begin
                            if (crc_cnt == CRC_LAST) begin
                                state <= ST_EOF;
                            end else begin
                                crc_cnt <= crc_cnt + 1'b1;
                            end
                        end
                    end
                    ST_EOF: begin
                        if (byte_start || (bit_tick && !bus_level)) begin
                            ev    <= '{done: 1'b1, ok: 1'b0, many: 1'b1, few: 1'b0};
                            state <= ST_IDLE;
                        end else if (bit_tick && eof_last) begin
                            ev    <= '{done: 1'b1, ok: 1'b1, many: 1'b0, few: 1'b0};
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy         = (state != ST_IDLE);
    assign resp_done    = ev.done;
    assign frame_ok     = ev.ok;
    assign err_too_many = ev.many;
    assign err_too_few  = ev.few;
    assign len_err      = ev.many || ev.few;
endmodule

// File: rtl/flc_checker.sv
module flc_checker (
    input logic clk,
    input logic rst,
    input logic abort,
    input logic to_enable,
    input logic to_clear,
    input logic busy,
    input logic resp_done,
    input logic frame_ok,
    input logic len_err,
    input logic err_too_many,
    input logic err_too_few,
    input logic timeout
);
    // R3
    ok_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
        frame_ok |-> resp_done && !len_err);

    // R4
    err_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
        len_err |-> resp_done && ($countones({err_too_many, err_too_few}) == 1));

    // R5
    cause_needs_err_chk: assert property (@(posedge clk) disable iff (rst)
        (err_too_many || err_too_few) |-> len_err);

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> !busy && !resp_done);

    // R8
    timeout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (timeout && !to_clear) |=> timeout);

    // R8
    timeout_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (to_clear && !to_enable) |=> !timeout);

    // R7
    timeout_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> $past(to_enable));
endmodule

bind frame_len_checker flc_checker u_flc_checker (
    .clk          (clk),
    .rst          (rst),
    .abort        (abort),
    .to_enable    (to_enable),
    .to_clear     (to_clear),
    .busy         (busy),
    .resp_done    (resp_done),
    .frame_ok     (frame_ok),
    .len_err      (len_err),
    .err_too_many (err_too_many),
    .err_too_few  (err_too_few),
    .timeout      (timeout)
);

// File: tb/frame_len_checker_bench.sv
module frame_len_checker_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic byte_start = 0, byte_done = 0, bit_tick = 0, bus_level = 1;
    logic [1:0] byte_kind = 0;
    logic long_frame = 0;
    logic [3:0] len_code = 0;
    logic [7:0] ext_len = 0;
    logic to_enable = 0, to_clear = 0, abort = 0;
    logic [7:0] to_limit = 8'd200;
    logic busy, resp_done, frame_ok, len_err, err_too_many, err_too_few, timeout;

    int checks = 0, errors = 0;
    int n_done = 0, n_ok = 0, n_err = 0, n_many = 0, n_few = 0;
    bit finished = 0;

    localparam logic [1:0] K_HEAD = 2'd0, K_INFO = 2'd1, K_BODY = 2'd2;

    always #4 clk = ~clk;

    frame_len_checker u_frame_len_checker (
        .clk(clk), .rst(rst), .byte_start(byte_start), .byte_done(byte_done),
        .byte_kind(byte_kind), .bit_tick(bit_tick), .bus_level(bus_level),
        .long_frame(long_frame), .len_code(len_code), .ext_len(ext_len),
        .to_enable(to_enable), .to_limit(to_limit), .to_clear(to_clear),
        .abort(abort), .busy(busy), .resp_done(resp_done), .frame_ok(frame_ok),
        .len_err(len_err), .err_too_many(err_too_many), .err_too_few(err_too_few),
        .timeout(timeout)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (resp_done)    n_done++;
            if (frame_ok)     n_ok++;
            if (len_err)      n_err++;
            if (err_too_many) n_many++;
            if (err_too_few)  n_few++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic zero_counts();
        n_done = 0; n_ok = 0; n_err = 0; n_many = 0; n_few = 0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [1:0] k);
        @(negedge clk) byte_start = 1;
        @(negedge clk) begin byte_start = 0; byte_done = 1; byte_kind = k; end
        @(negedge clk) byte_done = 0;
    endtask

    task automatic tick(input logic lvl);
        @(negedge clk) begin bus_level = lvl; bit_tick = 1; end
        @(negedge clk) begin bit_tick = 0; bus_level = 1; end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick(1'b1);
    endtask

    task automatic frame_body(input int ndata);
        send_byte(K_HEAD);
        send_byte(K_INFO);
        for (int i = 0; i < ndata; i++) send_byte(K_BODY);
        send_byte(K_BODY);
    endtask

    task automatic t_reset();
        check("R10 busy", busy, 0);
        check("R10 resp_done", resp_done, 0);
        check("R10 frame_ok", frame_ok, 0);
        check("R10 len_err", len_err, 0);
        check("R10 timeout", timeout, 0);
    endtask

    task automatic t_clean_normal();
        zero_counts();
        long_frame = 0; len_code = 4'd3;
        frame_body(3);
        check("R3 busy in eof", busy, 1);
        ticks(10);
        settle();
        check("R3 no ok before last tick", n_ok, 0);
        tick(1'b1);
        settle();
        check("R3 ok", n_ok, 1);
        check("R3 done", n_done, 1);
        check("R3 no err", n_err, 0);
        check("R3 idle", busy, 0);
    endtask

    task automatic t_long_select();
        zero_counts();
        long_frame = 1; len_code = 4'd3; ext_len = 8'd20;
        frame_body(20);
        ticks(11);
        settle();
        check("R1 long ok", n_ok, 1);
        check("R1 long no err", n_err, 0);
        long_frame = 0;
    endtask

    task automatic t_zero_len();
        zero_counts();
        len_code = 4'd0;
        frame_body(0);
        ticks(11);
        settle();
        check("R1 zero length ok", n_ok, 1);
    endtask

    task automatic t_info_first();
        zero_counts();
        len_code = 4'd2;
        send_byte(K_HEAD);
        send_byte(K_BODY);
        send_byte(K_BODY);
        send_byte(K_INFO);
        send_byte(K_BODY);
        send_byte(K_BODY);
        send_byte(K_BODY);
        ticks(11);
        settle();
        check("R2 pre-info bytes ignored ok", n_ok, 1);
        check("R2 no err", n_err, 0);
    endtask

    task automatic t_too_many_level();
        zero_counts();
        len_code = 4'd2;
        frame_body(2);
        ticks(10);
        tick(1'b0);
        settle();
        check("R4 err", n_err, 1);
        check("R4 too many", n_many, 1);
        check("R4 done still", n_done, 1);
        check("R4 no ok", n_ok, 0);
        check("R4 idle", busy, 0);
    endtask

    task automatic t_too_many_byte();
        zero_counts();
        len_code = 4'd1;
        frame_body(1);
        ticks(3);
        send_byte(K_BODY);
        settle();
        check("R4 extra byte too many", n_many, 1);
        check("R4 extra byte no ok", n_ok, 0);
    endtask

    task automatic t_too_few();
        zero_counts();
        len_code = 4'd4;
        send_byte(K_HEAD);
        send_byte(K_INFO);
        send_byte(K_BODY);
        ticks(9);
        send_byte(K_BODY);
        ticks(9);
        settle();
        check("R6 gap of nine no err", n_err, 0);
        check("R6 still busy", busy, 1);
        tick(1'b1);
        settle();
        check("R5 too few", n_few, 1);
        check("R5 err", n_err, 1);
        check("R5 done still", n_done, 1);
        check("R5 no ok", n_ok, 0);
        check("R5 idle", busy, 0);
    endtask

    task automatic t_timeout();
        zero_counts();
        to_enable = 1; to_limit = 8'd5; len_code = 4'd4;
        send_byte(K_HEAD);
        send_byte(K_INFO);
        ticks(5);
        settle();
        check("R7 no timeout at limit", timeout, 0);
        tick(1'b1);
        settle();
        check("R7 timeout set", timeout, 1);
        @(negedge clk) abort = 1;
        @(negedge clk) abort = 0;
        check("R9 abort idle", busy, 0);
        @(negedge clk) to_clear = 1;
        @(negedge clk) to_clear = 0;
        settle();
        check("R8 clear ignored while enabled", timeout, 1);
        to_enable = 0;
        settle();
        @(negedge clk) to_clear = 1;
        @(negedge clk) to_clear = 0;
        settle();
        check("R8 cleared after disable", timeout, 0);
        to_enable = 1;
        settle();
        check("R8 stays clear on re-enable", timeout, 0);
        to_enable = 0; to_limit = 8'd200;
    endtask

    task automatic t_abort();
        zero_counts();
        len_code = 4'd3;
        send_byte(K_HEAD);
        send_byte(K_INFO);
        send_byte(K_BODY);
        @(negedge clk) abort = 1;
        @(negedge clk) abort = 0;
        check("R9 busy low", busy, 0);
        ticks(12);
        settle();
        check("R9 no done", n_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_clean_normal();
        t_long_select();
        t_zero_len();
        t_info_first();
        t_too_many_level();
        t_too_many_byte();
        t_too_few();
        t_timeout();
        t_abort();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule